// File: doc/BRIEF.md
# Dual-Channel PCM Serial Output Formatter

This block drives one shared serial PCM output line for two voice channels. A frame begins on a frame sync input, and each channel owns a time slot that starts a programmable number of bit clocks after the frame start. In its slot a channel sends its already-encoded sample, MSB first, one bit per bit clock. Outside both slots the line is released (output enable low).

An 8-bit control register chooses the sample format (8-bit companded or 14-bit linear two's complement), the companding law, the frame sync style, and the power state of each channel. A channel in power saving still drives its slot, but with a fixed idle code that depends on the format and the law. A power-down input puts both channels into that idle state whatever the register holds. A synchronous reset returns the register to all zeros. Power saving and power-down leave the register alone, and it can still be written and read in both states. Three further register bits (a master clock rate flag and one filter flag per channel) are only stored and read back.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst` is high the register is cleared to 8'h00 and `pcm_oe` and `pcm_out` are driven low. The default therefore puts both channels in power saving, 8-bit, mu-law, long sync.
- R2: A cycle with `cfg_we` high stores `cfg_wdata`, and `cfg_rdata` shows it after the next rising clock edge. Without a write, `cfg_rdata` keeps its value.
- R3: Register bit 3 selects the format. With 0, a slot is 8 bits long and carries `chN_sample[7:0]`. With 1, a slot is 14 bits long and carries `chN_sample[13:0]`. In both cases the MSB goes first.
- R4: Register bit 2 selects the law, 0 for mu-law and 1 for A-law. It only changes the 8-bit idle code. Live samples are sent unchanged, and in linear mode the bit has no effect at all.
- R5: With register bit 4 at 0 (long sync), bit 0 of the frame is the clock edge where `fsync` is first sampled high. The output register presents that bit after that edge.
- R6: With register bit 4 at 1 (short sync), a one-cycle `fsync` pulse is sampled, and bit 0 of the frame is the following clock edge.
- R7: Register bit 0 is the run bit of channel 1 and bit 1 is the run bit of channel 2, where 1 means normal and 0 means power saving. A channel in power saving still drives its slot with its idle code: 8'hFF for mu-law, 8'hD5 for A-law, and 14'h0000 in linear mode.
- R8: While `pwr_down` is high, both channels send their idle codes whatever their run bits say. The register keeps its contents and still accepts writes.
- R9: Register bit 5 (clock rate flag), bit 6 (channel 2 filter flag) and bit 7 (channel 1 filter flag) are stored and read back, and they do not change the serial output.
- R10: `pcm_oe` is high exactly on the frame bit positions that fall inside a channel slot, counted from `chN_start`. When `pcm_oe` is low, `pcm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset, clears the register |
| pwr_down | input | 1 | Global power-down, forces both channels idle |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back |
| fsync | input | 1 | Frame sync |
| ch1_start | input | 8 | Channel 1 slot start, in bit clocks from the frame start |
| ch2_start | input | 8 | Channel 2 slot start, in bit clocks from the frame start |
| ch1_sample | input | 14 | Channel 1 encoded sample (low 8 bits used in 8-bit mode) |
| ch2_sample | input | 14 | Channel 2 encoded sample (low 8 bits used in 8-bit mode) |
| pcm_out | output | 1 | Serial PCM data |
| pcm_oe | output | 1 | Output enable for the shared line |

## Verification
The timing properties assume that `fsync` is low during reset, that a short-sync pulse lasts one cycle, and that the two slots neither overlap nor run past the frame counter's range. The stimulus keeps within these assumptions. It uses slots at offsets 2 and 20, raises `fsync` only from a quiet line, and holds `fsync` for eight cycles in long mode or one cycle in short mode. Register contents, slot offsets and samples change only between frames, never while a slot is being shifted out.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int LIN_W  = 14;
  localparam int COMP_W = 8;
  localparam int POS_W  = 8;
  localparam int N_CH   = 2;

  // register layout, bit 7 down to bit 0
  typedef struct packed {
    logic filt1;
    logic filt2;
    logic mclk_hi;
    logic short_fs;
    logic linear;
    logic alaw;
    logic run2;
    logic run1;
  } pcm_cfg_t;

  // idle code, left-justified in the linear width
  function automatic logic [LIN_W-1:0] idle_word(input logic linear, input logic alaw);
    if (linear) return '0;
    return {(alaw ? 8'hD5 : 8'hFF), {(LIN_W-COMP_W){1'b0}}};
  endfunction

  // live sample, left-justified in the linear width
  function automatic logic [LIN_W-1:0] live_word(input logic linear, input logic [LIN_W-1:0] smp);
    if (linear) return smp;
    return {smp[COMP_W-1:0], {(LIN_W-COMP_W){1'b0}}};
  endfunction
endpackage

// File: rtl/pcm_cfg_reg.sv
module pcm_cfg_reg
  import pcm_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  logic [7:0] wdata,
  output pcm_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= pcm_cfg_t'(wdata);
  end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  input  logic          short_mode,
  output logic [PW-1:0] pos,
  output logic          pos_vld
);
  logic          fs_q, fs_qq, run_q;
  logic [PW-1:0] cnt_q;
  logic          start;

  assign start = short_mode ? (fs_q & ~fs_qq) : (fsync & ~fs_q);

  always_comb begin
    if (start) begin
      pos     = '0;
      pos_vld = 1'b1;
    end else if (run_q && cnt_q != '1) begin
      pos     = cnt_q + 1'b1;
      pos_vld = 1'b1;
    end else begin
      pos     = cnt_q;
      pos_vld = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= 1'b0;
      fs_qq <= 1'b0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      fs_q  <= fsync;
      fs_qq <= fs_q;
      cnt_q <= pos;
      run_q <= pos_vld;
    end
  end
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter #(
  parameter int PW = 8,
  parameter int LW = 14,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic          pos_vld,
  input  logic [PW-1:0] start_ofs,
  input  logic          linear,
  input  logic [LW-1:0] word,
  output logic          bit_o,
  output logic          act_o
);
  localparam logic [PW-1:0] LEN_LIN  = PW'(LW);
  localparam logic [PW-1:0] LEN_COMP = PW'(CW);

  logic [LW-1:0] sh_q;
  logic [PW-1:0] diff, len;
  logic          first;

  assign len   = linear ? LEN_LIN : LEN_COMP;
  assign diff  = pos - start_ofs;
  assign act_o = pos_vld && (pos >= start_ofs) && (diff < len);
  assign first = act_o && (diff == '0);
  assign bit_o = first ? word[LW-1] : sh_q[LW-1];

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (first) sh_q <= word << 1;
    else if (act_o) sh_q <= sh_q << 1;
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int PW = POS_W,
  parameter int LW = LIN_W,
  parameter int CW = COMP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_down,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          fsync,
  input  logic [PW-1:0] ch1_start,
  input  logic [PW-1:0] ch2_start,
  input  logic [LW-1:0] ch1_sample,
  input  logic [LW-1:0] ch2_sample,
  output logic          pcm_out,
  output logic          pcm_oe
);
  pcm_cfg_t      cfg;
  logic [PW-1:0] pos;
  logic          pos_vld;
  logic [LW-1:0] smp   [N_CH];
  logic [PW-1:0] ofs   [N_CH];
  logic [LW-1:0] word  [N_CH];
  logic [N_CH-1:0] run, bits, act;

  assign smp[0] = ch1_sample;
  assign smp[1] = ch2_sample;
  assign ofs[0] = ch1_start;
  assign ofs[1] = ch2_start;
  assign run    = {cfg.run2, cfg.run1};
  assign cfg_rdata = cfg;

  pcm_cfg_reg u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  pcm_frame_timer #(.PW(PW)) u_tmr (
    .clk(clk), .rst(rst), .fsync(fsync), .short_mode(cfg.short_fs),
    .pos(pos), .pos_vld(pos_vld)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // power-down overrides the per-channel run bit
    assign word[c] = (pwr_down || !run[c]) ? idle_word(cfg.linear, cfg.alaw)
                                           : live_word(cfg.linear, smp[c]);
    pcm_slot_shifter #(.PW(PW), .LW(LW), .CW(CW)) u_sh (
      .clk(clk), .rst(rst), .pos(pos), .pos_vld(pos_vld),
      .start_ofs(ofs[c]), .linear(cfg.linear), .word(word[c]),
      .bit_o(bits[c]), .act_o(act[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_out <= 1'b0;
      pcm_oe  <= 1'b0;
    end else if (act[0]) begin
      pcm_out <= bits[0];
      pcm_oe  <= 1'b1;
    end else if (act[1]) begin
      pcm_out <= bits[1];
      pcm_oe  <= 1'b1;
    end else begin
      pcm_out <= 1'b0;
      pcm_oe  <= 1'b0;
    end
  end
endmodule

module pcm_serial_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       fsync,
  input logic [7:0] ch1_start,
  input logic       pcm_out,
  input logic       pcm_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (cfg_rdata == 8'h00 && !pcm_oe));
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));
  // R10
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst) !pcm_oe |-> !pcm_out);
  // R5
  long_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rdata[4] && fsync && !$past(fsync) && ch1_start == 8'd0) |=> pcm_oe);
  // R6
  short_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[4] && !fsync && $past(fsync) && !$past(fsync, 2) && ch1_start == 8'd0) |=> pcm_oe);
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .fsync(fsync), .ch1_start(ch1_start),
  .pcm_out(pcm_out), .pcm_oe(pcm_oe)
);

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NPOS = 40;

  logic clk = 0, rst = 1, pwr_down = 0, cfg_we = 0, fsync = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [7:0] ch1_start = 8'd2, ch2_start = 8'd20;
  logic [13:0] ch1_sample = 14'h3A5C, ch2_sample = 14'h1234;
  logic pcm_out, pcm_oe;
  logic cap_d [NPOS];
  logic cap_oe [NPOS];
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serial_tx u0 (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fsync(fsync),
    .ch1_start(ch1_start), .ch2_start(ch2_start),
    .ch1_sample(ch1_sample), .ch2_sample(ch2_sample),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // expected slot word, left-justified in 14 bits
  function automatic logic [13:0] exp_word(input logic [7:0] cfg, input bit pdn, input int ch, input logic [13:0] s);
    bit run = (ch == 0) ? cfg[0] : cfg[1];
    if (pdn || !run) begin
      if (cfg[3]) return 14'h0;
      return {(cfg[2] ? 8'hD5 : 8'hFF), 6'b0};
    end
    if (cfg[3]) return s;
    return {s[7:0], 6'b0};
  endfunction

  task automatic run_frame(input bit short_m);
    @(negedge clk); fsync = 1;
    if (short_m) begin
      @(negedge clk); fsync = 0;
    end
    for (int i = 0; i < NPOS; i++) begin
      @(negedge clk);
      cap_d[i] = pcm_out;
      cap_oe[i] = pcm_oe;
      if (!short_m && i == 7) fsync = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_test(input string req, input logic [7:0] cfg);
    logic [13:0] w1, w2;
    int len, bad;
    logic eo, ed;
    w1 = exp_word(cfg, pwr_down, 0, ch1_sample);
    w2 = exp_word(cfg, pwr_down, 1, ch2_sample);
    len = cfg[3] ? 14 : 8;
    run_frame(cfg[4]);
    bad = -1; eo = 0; ed = 0;
    for (int p = 0; p < NPOS; p++) begin
      logic o, d;
      o = 0; d = 0;
      if (p >= ch1_start && p < ch1_start + len) begin o = 1; d = w1[13-(p-ch1_start)]; end
      else if (p >= ch2_start && p < ch2_start + len) begin o = 1; d = w2[13-(p-ch2_start)]; end
      if (bad < 0 && (cap_oe[p] !== o || cap_d[p] !== d)) begin bad = p; eo = o; ed = d; end
    end
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, $sformatf("%s pos %0d oe/out", req, bad), {cap_oe[bad], cap_d[bad]}, {eo, ed});
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 register default", cfg_rdata, 8'h00);
    chk(pcm_oe == 0, "R1 oe low in reset", pcm_oe, 0);
    rst = 0;
    frame_test("R1 R7 default idle mu-law both", 8'h00);
  endtask

  task automatic t_regs;
    wr(8'hE5);
    chk(cfg_rdata == 8'hE5, "R2 readback", cfg_rdata, 8'hE5);
    wr(8'h1A);
    repeat (5) @(negedge clk);
    chk(cfg_rdata == 8'h1A, "R2 hold without write", cfg_rdata, 8'h1A);
  endtask

  task automatic t_mulaw;
    wr(8'h03);
    frame_test("R3 R5 8-bit long frame live", 8'h03);
  endtask

  task automatic t_short;
    ch1_sample = 14'h0096; ch2_sample = 14'h2A71;
    wr(8'h17);
    frame_test("R4 R6 A-law short frame live", 8'h17);
  endtask

  task automatic t_linear;
    ch1_sample = 14'h2C3B; ch2_sample = 14'h1F05;
    wr(8'h0F);
    frame_test("R3 R4 linear live, law ignored", 8'h0F);
    wr(8'h0D);
    frame_test("R4 R7 linear idle ch2 zero", 8'h0D);
    wr(8'h09);
    frame_test("R7 linear idle ch2 mu-law bit", 8'h09);
  endtask

  task automatic t_saving;
    wr(8'h02);
    frame_test("R7 ch1 saving mu-law FF", 8'h02);
    wr(8'h05);
    frame_test("R7 ch2 saving A-law D5", 8'h05);
  endtask

  task automatic t_pdn;
    wr(8'h03);
    pwr_down = 1;
    frame_test("R8 power-down overrides run bits", 8'h03);
    chk(cfg_rdata == 8'h03, "R8 register kept in power-down", cfg_rdata, 8'h03);
    wr(8'h17);
    chk(cfg_rdata == 8'h17, "R8 write in power-down", cfg_rdata, 8'h17);
    frame_test("R8 power-down A-law short idle", 8'h17);
    pwr_down = 0;
    frame_test("R8 live after power-down", 8'h17);
  endtask

  task automatic t_misc;
    wr(8'hE3);
    chk(cfg_rdata == 8'hE3, "R9 flag bits stored", cfg_rdata, 8'hE3);
    frame_test("R9 flag bits no effect", 8'hE3);
  endtask

  task automatic t_reset2;
    wr(8'h1F);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(cfg_rdata == 8'h00, "R1 reset restores default", cfg_rdata, 8'h00);
    frame_test("R1 R10 idle after reset", 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_mulaw();
    t_short();
    t_linear();
    t_saving();
    t_pdn();
    t_misc();
    t_reset2();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule